// File: doc/BRIEF.md
# Power-On Strap Capture and Test-Mode Decoder

This block sits beside two shared configuration pads of a clock generator. While power-on reset is held low, the pads are inputs: their output drivers are off, and the levels pulled onto them by board resistors are recorded each reference-clock cycle. When reset is released, the record is frozen and the pads are handed over to the clock drivers by raising their output enables. The record stays frozen until reset is asserted again.

A third select bit comes from a dedicated pin that is never latched. It passes through a two-stage synchronizer and is joined to the frozen strap bits to form a three-bit select word. One value of that word selects a production test mode. In that mode every output clock group runs at a fixed division of the reference: the reference group undivided, the fast group at half, and the slow group at a quarter. The test flag and the per-group divider codes are registered, so they change only on clock edges.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: `pad_oe_o` is all zeros after any clock edge at which `por_n` is low, and all ones after any clock edge at which `por_n` is high.
- R2: At every clock edge with `por_n` low, the strap register takes `pad_i`. `cfg_sel_o[1]` shows `pad_i[0]` and `cfg_sel_o[2]` shows `pad_i[1]`, so after release they hold the pad levels from the last edge at which reset was low.
- R3: While `por_n` stays high, changes on `pad_i` have no effect on `cfg_sel_o[2:1]`.
- R4: `cfg_sel_o[0]` equals the `live_sel_i` level sampled two clock edges earlier. It is 0 after any edge with `por_n` low and for the first two edges after release.
- R5: `test_mode_o` is 1 after an edge with `por_n` high exactly when `cfg_sel_o` held 3'b011 just before that edge (bit 0 live select = 1, bit 1 = 1, bit 2 = 0). Otherwise it is 0, and it is 0 after any edge with `por_n` low.
- R6: `div_sel_o` carries three 2-bit codes: group 0 (reference outputs) in bits [1:0], group 1 (fast outputs) in bits [3:2], and group 2 (slow outputs) in bits [5:4]. The code values are 00 for the normal PLL path, 01 for the reference undivided, 10 for reference/2 and 11 for reference/4. In test mode the value is 6'b11_10_01; outside test mode it is 6'b000000.
- R7: `test_mode_o` and `div_sel_o` are updated on the same edge as each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, sampled on `clk` |
| pad_i | input | 2 | Levels read from the shared configuration pads |
| pad_oe_o | output | 2 | Output enable for each shared pad's clock driver |
| live_sel_i | input | 1 | Unlatched select bit, asynchronous |
| cfg_sel_o | output | 3 | Select word: {strap bit 2, strap bit 1, synchronized live bit} |
| test_mode_o | output | 1 | Production test mode active |
| div_sel_o | output | 6 | Divider codes for the three output groups |

## Verification
Two functions can fall into the same edge: reset assertion or release, and a change of the live select that completes or breaks the test pattern. The bench drives the live select and the pad levels on the same cycle in which `por_n` rises or falls. It also drops reset while test mode is active. A behavioural model built on a queue for the synchronizer delay predicts every output after each edge, so any ordering error in freezing the straps, clearing the synchronizer or dropping the test flag shows up as a miscompare on that cycle.

// File: rtl/strap_cfg_pkg.sv
// Shared constants for the strap capture block.
// Assumes three output clock groups; the divider codes are fixed by the decode.
package strap_cfg_pkg;

    typedef enum logic [1:0] {
        DIV_PLL = 2'd0,
        DIV_BY1 = 2'd1,
        DIV_BY2 = 2'd2,
        DIV_BY4 = 2'd3
    } div_code_e;

    localparam int GRP_REF  = 0;
    localparam int GRP_FAST = 1;
    localparam int GRP_SLOW = 2;
    localparam int NUM_GRP  = 3;

    // Divider code that a group takes while production test mode is active.
    function automatic logic [1:0] test_div(input int grp);
        case (grp)
            GRP_REF:  return DIV_BY1;
            GRP_FAST: return DIV_BY2;
            GRP_SLOW: return DIV_BY4;
            default:  return DIV_PLL;
        endcase
    endfunction

endpackage

// File: rtl/strap_capture.sv
// Records pad levels on every edge while power-on reset is low and freezes them on release.
// Also owns the pad output enables: drivers stay off during reset and turn on after release.
// Assumes por_n is already synchronous to clk.
module strap_capture #(
    parameter int STRAP_W = 2
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] pad_i,
    output logic [STRAP_W-1:0] strap_o,
    output logic [STRAP_W-1:0] oe_o
);

    logic [STRAP_W-1:0] strap_q;
    logic [STRAP_W-1:0] oe_q;

    // Strap register: tracks the pads during reset, holds afterwards.
    always_ff @(posedge clk) begin
        if (!por_n) strap_q <= pad_i;
    end

    // Output enables: cleared during reset, set once reset is released.
    always_ff @(posedge clk) begin
        if (!por_n) oe_q <= '0;
        else        oe_q <= '1;
    end

    assign strap_o = strap_q;
    assign oe_o    = oe_q;

    // Checks start after the first edge.
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    assert_oe_off_in_por_R1: assert property (@(posedge clk) disable iff (!armed)
        !por_n |=> (oe_q == '0));
    assert_oe_on_after_por_R1: assert property (@(posedge clk) disable iff (!armed)
        por_n |=> (oe_q == '1));
    assert_strap_frozen_R3: assert property (@(posedge clk) disable iff (!armed)
        por_n |=> $stable(strap_q));
    assert_strap_tracks_R2: assert property (@(posedge clk) disable iff (!armed)
        !por_n |=> (strap_q == $past(pad_i)));

endmodule

// File: rtl/sel_sync.sv
// Multi-stage synchronizer for the live select bit.
// Assumes SYNC_STAGES >= 2; every stage is cleared by power-on reset.
module sel_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic async_i,
    output logic sync_o
);

    logic [SYNC_STAGES-1:0] stg_q;

    genvar s;
    generate
        for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: samples the asynchronous pin.
                always_ff @(posedge clk) begin
                    if (!por_n) stg_q[0] <= 1'b0;
                    else        stg_q[0] <= async_i;
                end
            end else begin : g_next
                // Later stages: shift from the previous stage.
                always_ff @(posedge clk) begin
                    if (!por_n) stg_q[s] <= 1'b0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[SYNC_STAGES-1];

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    assert_sync_clear_R4: assert property (@(posedge clk) disable iff (!armed)
        !por_n |=> (sync_o == 1'b0));
    assert_sync_shift_R4: assert property (@(posedge clk) disable iff (!armed)
        por_n |=> (sync_o == $past(stg_q[SYNC_STAGES-2])));

endmodule

// File: rtl/mode_decode.sv
// Registered decode of the select word into the test-mode flag and per-group divider codes.
// Assumes sel_i is built only from registers, so its value is stable between edges.
module mode_decode
    import strap_cfg_pkg::*;
#(
    parameter int              SEL_W        = 3,
    parameter logic [SEL_W-1:0] TEST_PATTERN = 3'b011
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic [SEL_W-1:0]     sel_i,
    output logic                 test_o,
    output logic [2*NUM_GRP-1:0] div_o
);

    localparam int DIV_W = 2 * NUM_GRP;

    logic             hit;
    logic             test_q;
    logic [DIV_W-1:0] div_q;

    // Pattern match on the current select word.
    always_comb hit = (sel_i == TEST_PATTERN);

    // Test flag register.
    always_ff @(posedge clk) begin
        if (!por_n) test_q <= 1'b0;
        else        test_q <= hit;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : g_grp
            // Divider code register for one output group.
            always_ff @(posedge clk) begin
                if (!por_n)   div_q[2*g +: 2] <= DIV_PLL;
                else if (hit) div_q[2*g +: 2] <= test_div(g);
                else          div_q[2*g +: 2] <= DIV_PLL;
            end
        end
    endgenerate

    assign test_o = test_q;
    assign div_o  = div_q;

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    assert_test_on_match_R5: assert property (@(posedge clk) disable iff (!armed)
        (por_n && (sel_i == TEST_PATTERN)) |=> test_q);
    assert_test_off_mismatch_R5: assert property (@(posedge clk) disable iff (!armed)
        (!por_n || (sel_i != TEST_PATTERN)) |=> !test_q);
    assert_div_idle_R6: assert property (@(posedge clk) disable iff (!armed)
        (!por_n || (sel_i != TEST_PATTERN)) |=> (div_q == '0));

endmodule

// File: rtl/strap_cfg_ctrl.sv
// Top level: strap capture, live select synchronizer and registered test-mode decode.
// Assumes por_n is synchronous to clk and live_sel_i may be fully asynchronous.
module strap_cfg_ctrl
    import strap_cfg_pkg::*;
#(
    parameter int                 STRAP_W      = 2,
    parameter int                 SYNC_STAGES  = 2,
    parameter logic [STRAP_W:0]   TEST_PATTERN = 3'b011
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic [STRAP_W-1:0]   pad_i,
    output logic [STRAP_W-1:0]   pad_oe_o,
    input  logic                 live_sel_i,
    output logic [STRAP_W:0]     cfg_sel_o,
    output logic                 test_mode_o,
    output logic [2*NUM_GRP-1:0] div_sel_o
);

    localparam int SEL_W = STRAP_W + 1;

    logic [STRAP_W-1:0] strap;
    logic               live_s;
    logic [SEL_W-1:0]   sel;

    strap_capture #(.STRAP_W(STRAP_W)) u_cap (
        .clk    (clk),
        .por_n  (por_n),
        .pad_i  (pad_i),
        .strap_o(strap),
        .oe_o   (pad_oe_o)
    );

    sel_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .por_n  (por_n),
        .async_i(live_sel_i),
        .sync_o (live_s)
    );

    // Select word: latched straps above, live bit at position 0.
    always_comb sel = {strap, live_s};

    mode_decode #(.SEL_W(SEL_W), .TEST_PATTERN(TEST_PATTERN)) u_dec (
        .clk   (clk),
        .por_n (por_n),
        .sel_i (sel),
        .test_o(test_mode_o),
        .div_o (div_sel_o)
    );

    assign cfg_sel_o = sel;

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    assert_div_with_flag_R7: assert property (@(posedge clk) disable iff (!armed)
        $rose(test_mode_o) |-> (div_sel_o != '0));

endmodule

// File: tb/test_strap_cfg_ctrl.sv
module test_strap_cfg_ctrl;

    logic       clk = 1'b0;
    logic       por_n;
    logic [1:0] pad_i;
    logic [1:0] pad_oe_o;
    logic       live_sel_i;
    logic [2:0] cfg_sel_o;
    logic       test_mode_o;
    logic [5:0] div_sel_o;

    int vectors  = 0;
    int failures = 0;
    int cycles   = 0;
    bit started  = 1'b0;

    always #4 clk = ~clk;

    strap_cfg_ctrl i_strap_cfg_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .pad_i      (pad_i),
        .pad_oe_o   (pad_oe_o),
        .live_sel_i (live_sel_i),
        .cfg_sel_o  (cfg_sel_o),
        .test_mode_o(test_mode_o),
        .div_sel_o  (div_sel_o)
    );

    // Behavioural reference state.
    logic [1:0] m_strap;
    logic [1:0] m_oe;
    logic       m_test;
    logic [5:0] m_div;
    bit         dly[$];

    always @(posedge clk) begin
        cycles++;
        if (!por_n) begin
            m_strap = pad_i;
            m_oe    = 2'b00;
            m_test  = 1'b0;
            m_div   = 6'b0;
            dly     = {1'b0, 1'b0};
        end else begin
            m_test = (m_strap == 2'b01) && dly[0];
            m_div  = m_test ? 6'b11_10_01 : 6'b0;
            m_oe   = 2'b11;
            void'(dly.pop_front());
            dly.push_back(live_sel_i);
        end
        started = 1'b1;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, cycles, act, exp);
        end
    endtask

    // Compare every output halfway through each cycle.
    always @(negedge clk) begin
        if (started) begin
            chk("R1 pad_oe",   {6'b0, pad_oe_o},      {6'b0, m_oe});
            chk("R2/R3 strap", {6'b0, cfg_sel_o[2:1]}, {6'b0, m_strap});
            chk("R4 live",     {7'b0, cfg_sel_o[0]},  {7'b0, dly[0]});
            chk("R5 test",     {7'b0, test_mode_o},   {7'b0, m_test});
            chk("R6/R7 div",   {2'b0, div_sel_o},     {2'b0, m_div});
        end
    end

    task automatic step(input logic p, input logic [1:0] pads, input logic live);
        @(negedge clk);
        #1;
        por_n      = p;
        pad_i      = pads;
        live_sel_i = live;
    endtask

    initial begin
        por_n = 1'b0; pad_i = 2'b01; live_sel_i = 1'b1;
        // R2: pads move during reset, last value wins.
        step(0, 2'b10, 1); step(0, 2'b11, 0); step(0, 2'b01, 1);
        // Release with live=1: test pattern 011 reached after sync delay (R4, R5, R6).
        step(1, 2'b10, 1);
        for (int i = 0; i < 6; i++) step(1, pad_i, 1'b1);
        // R3: pads wiggle while running; live toggles test on and off.
        for (int i = 0; i < 60; i++) step(1, 2'($urandom), 1'($urandom));
        // Reset dropped while test mode may be active, with live changing on the same cycle.
        step(1, 2'b01, 1); step(1, 2'b01, 1); step(1, 2'b01, 1);
        step(0, 2'b11, 0);
        step(0, 2'b11, 1);
        // R5: every strap combination with a live stream.
        for (int c = 0; c < 4; c++) begin
            step(0, 2'(c), 1'b1);
            step(0, 2'(c), 1'b1);
            step(1, 2'(~c), 1'b1);
            for (int i = 0; i < 30; i++) step(1, 2'($urandom), (i % 7) < 4);
        end
        // Short reset pulses of one cycle.
        for (int i = 0; i < 40; i++) step(i % 9 != 0, 2'($urandom), 1'($urandom));
        step(1, 2'b00, 0); step(1, 2'b00, 0); step(1, 2'b00, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

endmodule